// File: doc/BRIEF.md
# Fuse Array Command Controller with Program Unlock

This block sits between a CPU register bus and a one-time-programmable fuse array. The array is held internally as a row memory of 1024 rows, each with 32 data bits and a 9-bit check field. Software selects a row and a command through a small register bank, raises a start bit, and waits for a command-done flag. Two commands act on the array: a read, which returns the data and check field of a row, and a program-word, which can only turn fuse bits from 0 to 1.

Programming is guarded. The array accepts a program-word only after the program-enable command has completed four times with the write-data words 0xF, 0x4, 0x8 and 0xD, in that order. That sequence raises a program-ok flag. The flag drops after a program-word completes, and also when software withdraws CPU access. On reads, a check function of the data bits can be compared with the stored check field. When programming, that function can supply the check field in place of the value in the write-data register.

The command sequencer has five named states. FILL clears every row after reset and then moves to IDLE. IDLE moves to FETCH when the start bit is high and CPU access is enabled. FETCH reads the selected row and moves to APPLY. APPLY completes the command and moves to RELEASE. RELEASE moves back to IDLE once software drops the start bit.

The unlock machine has five states. WAIT_F, WAIT_4, WAIT_8 and WAIT_D each advance on a program-enable carrying the expected word. WAIT_D then moves to OPEN. Every other command completion returns the machine to WAIT_F, and so does clearing CPU access. OPEN returns to WAIT_F when a program-word completes.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, status word 0 (index 5) and status word 1 (index 6) read 0. The init-done flag (status 0 bit 3) stays 0 until all 1024 rows have been cleared, one row per cycle, and then reads 1. Every row then reads as zero.
- R2: The register indices are: mode 0, write-data low 1, write-data high 2, row select 3, command 4, status 0 at 5, status 1 at 6, read-data low 7, read-data high 8. In the command register, bit 0 is start and bits 5:1 hold the opcode. A command starts only while mode bit 15 (CPU access) is 1. With mode bit 15 at 0, a raised start bit runs nothing and command-done stays 0.
- R3: Command-done (status 1 bit 1) is set when a command completes. It stays set until a 1 is written to that bit. A write of 0 to it has no effect. After a completion, no new command starts until software has dropped the start bit.
- R4: A read (opcode 0) of the row in row-select bits 15:6 returns the data bits in read-data low. It returns the check field in read-data high bits 8:0, and bits 31:9 of read-data high read 0. Row-select bits above 15 are ignored.
- R5: Four program-enable completions (opcode 2), with write-data low equal to 0xF, 0x4, 0x8 and 0xD in that order, set program-ok (status 0 bit 2).
- R6: A wrong word, or any command other than program-enable, before the fourth word returns the sequence to its start, and program-ok stays 0.
- R7: A program-word (opcode 10) with program-ok set ORs the new data and check field into the selected row. Without program-ok, the row is left unchanged, but command-done still sets.
- R8: Program-ok clears when a program-word completes and when mode bit 15 is cleared.
- R9: With mode bit 8 set, a program-word writes a check field equal to the check function of write-data low. With bit 8 clear, it writes write-data high bits 8:0. The check function sets bit i to the XOR of every data bit j for which j mod 9 equals i.
- R10: A read sets ECC-detect (status 1 bit 17) when the stored check field differs from the check function of the stored data and mode bit 9 is 0. With mode bit 9 at 1, the read leaves ECC-detect at 0. Each read replaces the flag, and a write of 1 to bit 17 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_idx | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when the strobe is low |

## Verification
The bench sends broken unlock sequences: a wrong third word, and a read command slipped in before the last word. A design that only counted four program-enables, or ignored commands in between, would raise program-ok and then corrupt a row. It checks that program-ok drops after a single program-word and when CPU access is withdrawn. A design that held the flag would allow a second write with no new unlock. It programs the same row twice to confirm that bits accumulate and are never cleared, and it writes deliberately inconsistent check fields. A design with ECC-detect tied low, or that ignored the disable bit, would then report the wrong flag.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 9;
    localparam int ROW_W  = DATA_W + CHK_W;
    localparam int OP_W   = 5;

    localparam logic [OP_W-1:0] OP_READ    = 5'd0;
    localparam logic [OP_W-1:0] OP_PENABLE = 5'd2;
    localparam logic [OP_W-1:0] OP_PWORD   = 5'd10;

    localparam logic [3:0] IDX_MODE  = 4'd0;
    localparam logic [3:0] IDX_WLO   = 4'd1;
    localparam logic [3:0] IDX_WHI   = 4'd2;
    localparam logic [3:0] IDX_ROW   = 4'd3;
    localparam logic [3:0] IDX_CMD   = 4'd4;
    localparam logic [3:0] IDX_STAT0 = 4'd5;
    localparam logic [3:0] IDX_STAT1 = 4'd6;
    localparam logic [3:0] IDX_RLO   = 4'd7;
    localparam logic [3:0] IDX_RHI   = 4'd8;

    localparam int BIT_CPU_EN  = 15;
    localparam int BIT_ECC_OFF = 9;
    localparam int BIT_ECC_WR  = 8;
    localparam int ROW_LSB     = 6;
    localparam int BIT_INIT    = 3;
    localparam int BIT_PROG_OK = 2;
    localparam int BIT_DONE    = 1;
    localparam int BIT_ECC_ERR = 17;

    function automatic logic [CHK_W-1:0] chk_of(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        c = '0;
        for (int j = 0; j < DATA_W; j++) begin
            c[j % CHK_W] = c[j % CHK_W] ^ d[j];
        end
        return c;
    endfunction
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ROW_W-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ROW_W-1:0]  wr_data
);
    localparam int ROWS = 1 << ADDR_W;

    logic [ROW_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
        rd_data <= cells[rd_addr];
    end
endmodule

// File: rtl/otp_unlock.sv
module otp_unlock
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_en,
    input  logic              pe_evt,
    input  logic              pw_evt,
    input  logic              other_evt,
    input  logic [DATA_W-1:0] word,
    output logic              prog_ok
);
    typedef enum logic [2:0] {
        UL_WAIT_F,
        UL_WAIT_4,
        UL_WAIT_8,
        UL_WAIT_D,
        UL_OPEN
    } ul_state_t;

    ul_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UL_WAIT_F;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!cpu_en) begin
            state_d = UL_WAIT_F;
        end else begin
            unique case (state_q)
                UL_WAIT_F: begin
                    if (pe_evt && word == 32'hF) state_d = UL_WAIT_4;
                end
                UL_WAIT_4: begin
                    if (pe_evt) state_d = (word == 32'h4) ? UL_WAIT_8 : UL_WAIT_F;
                    else if (pw_evt || other_evt) state_d = UL_WAIT_F;
                end
                UL_WAIT_8: begin
                    if (pe_evt) state_d = (word == 32'h8) ? UL_WAIT_D : UL_WAIT_F;
                    else if (pw_evt || other_evt) state_d = UL_WAIT_F;
                end
                UL_WAIT_D: begin
                    if (pe_evt) state_d = (word == 32'hD) ? UL_OPEN : UL_WAIT_F;
                    else if (pw_evt || other_evt) state_d = UL_WAIT_F;
                end
                UL_OPEN: begin
                    if (pw_evt) state_d = UL_WAIT_F;
                end
                default: state_d = UL_WAIT_F;
            endcase
        end
    end

    always_comb begin
        prog_ok = (state_q == UL_OPEN);
    end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [3:0]        bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cpu_en,
    output logic              ecc_off,
    output logic              ecc_wr,
    output logic [DATA_W-1:0] wlo,
    output logic [CHK_W-1:0]  whi,
    output logic [ADDR_W-1:0] row,
    output logic              go,
    output logic [OP_W-1:0]   op,
    output logic              cmd_done,
    output logic              ecc_err,
    input  logic              init_done,
    input  logic              prog_ok,
    input  logic              done_set,
    input  logic              rd_cap,
    input  logic [DATA_W-1:0] rd_lo,
    input  logic [CHK_W-1:0]  rd_hi,
    input  logic              rd_ecc
);
    logic [DATA_W-1:0] rlo_q;
    logic [CHK_W-1:0]  rhi_q;
    logic              wr_hit;

    always_comb begin
        wr_hit = bus_en && bus_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en   <= 1'b0;
            ecc_off  <= 1'b0;
            ecc_wr   <= 1'b0;
            wlo      <= '0;
            whi      <= '0;
            row      <= '0;
            go       <= 1'b0;
            op       <= '0;
            cmd_done <= 1'b0;
            ecc_err  <= 1'b0;
            rlo_q    <= '0;
            rhi_q    <= '0;
        end else begin
            if (wr_hit) begin
                unique case (bus_idx)
                    IDX_MODE: begin
                        cpu_en  <= bus_wdata[BIT_CPU_EN];
                        ecc_off <= bus_wdata[BIT_ECC_OFF];
                        ecc_wr  <= bus_wdata[BIT_ECC_WR];
                    end
                    IDX_WLO: wlo <= bus_wdata;
                    IDX_WHI: whi <= bus_wdata[CHK_W-1:0];
                    IDX_ROW: row <= bus_wdata[ROW_LSB +: ADDR_W];
                    IDX_CMD: begin
                        go <= bus_wdata[0];
                        op <= bus_wdata[OP_W:1];
                    end
                    default: ;
                endcase
            end
            if (done_set) begin
                cmd_done <= 1'b1;
            end else if (wr_hit && bus_idx == IDX_STAT1 && bus_wdata[BIT_DONE]) begin
                cmd_done <= 1'b0;
            end
            if (rd_cap) begin
                ecc_err <= rd_ecc;
                rlo_q   <= rd_lo;
                rhi_q   <= rd_hi;
            end else if (wr_hit && bus_idx == IDX_STAT1 && bus_wdata[BIT_ECC_ERR]) begin
                ecc_err <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            unique case (bus_idx)
                IDX_MODE: begin
                    bus_rdata[BIT_CPU_EN]  = cpu_en;
                    bus_rdata[BIT_ECC_OFF] = ecc_off;
                    bus_rdata[BIT_ECC_WR]  = ecc_wr;
                end
                IDX_WLO: bus_rdata = wlo;
                IDX_WHI: bus_rdata[CHK_W-1:0] = whi;
                IDX_ROW: bus_rdata[ROW_LSB +: ADDR_W] = row;
                IDX_CMD: begin
                    bus_rdata[0]      = go;
                    bus_rdata[OP_W:1] = op;
                end
                IDX_STAT0: begin
                    bus_rdata[BIT_INIT]    = init_done;
                    bus_rdata[BIT_PROG_OK] = prog_ok;
                end
                IDX_STAT1: begin
                    bus_rdata[BIT_DONE]    = cmd_done;
                    bus_rdata[BIT_ECC_ERR] = ecc_err;
                end
                IDX_RLO: bus_rdata = rlo_q;
                IDX_RHI: bus_rdata[CHK_W-1:0] = rhi_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [OP_W-1:0]   op,
    input  logic              cpu_en,
    input  logic              ecc_off,
    input  logic              ecc_wr,
    input  logic [ADDR_W-1:0] row,
    input  logic [DATA_W-1:0] wlo,
    input  logic [CHK_W-1:0]  whi,
    input  logic              prog_ok,
    input  logic [ROW_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ROW_W-1:0]  mem_wdata,
    output logic              init_done,
    output logic              done_set,
    output logic              rd_cap,
    output logic [DATA_W-1:0] rd_lo,
    output logic [CHK_W-1:0]  rd_hi,
    output logic              rd_ecc,
    output logic              pe_evt,
    output logic              pw_evt,
    output logic              other_evt
);
    typedef enum logic [2:0] {
        S_FILL,
        S_IDLE,
        S_FETCH,
        S_APPLY,
        S_RELEASE
    } seq_state_t;

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] fill_q;
    logic [ADDR_W-1:0] lat_row;
    logic [OP_W-1:0]   lat_op;
    logic [CHK_W-1:0]  new_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FILL;
            fill_q  <= '0;
            lat_row <= '0;
            lat_op  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_FILL) begin
                fill_q <= fill_q + 1'b1;
            end
            if (state_q == S_IDLE && state_d == S_FETCH) begin
                lat_row <= row;
                lat_op  <= op;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FILL:    if (&fill_q) state_d = S_IDLE;
            S_IDLE:    if (go && cpu_en) state_d = S_FETCH;
            S_FETCH:   state_d = S_APPLY;
            S_APPLY:   state_d = S_RELEASE;
            S_RELEASE: if (!go) state_d = S_IDLE;
            default:   state_d = S_FILL;
        endcase
    end

    always_comb begin
        new_chk   = ecc_wr ? chk_of(wlo) : whi;
        mem_raddr = lat_row;
        mem_we    = 1'b0;
        mem_waddr = lat_row;
        mem_wdata = '0;
        init_done = 1'b1;
        done_set  = 1'b0;
        rd_cap    = 1'b0;
        rd_lo     = mem_rdata[DATA_W-1:0];
        rd_hi     = mem_rdata[ROW_W-1:DATA_W];
        rd_ecc    = 1'b0;
        pe_evt    = 1'b0;
        pw_evt    = 1'b0;
        other_evt = 1'b0;
        unique case (state_q)
            S_FILL: begin
                init_done = 1'b0;
                mem_we    = 1'b1;
                mem_waddr = fill_q;
            end
            S_APPLY: begin
                done_set = 1'b1;
                if (lat_op == OP_READ) begin
                    rd_cap    = 1'b1;
                    rd_ecc    = !ecc_off && (rd_hi != chk_of(rd_lo));
                    other_evt = 1'b1;
                end else if (lat_op == OP_PENABLE) begin
                    pe_evt = 1'b1;
                end else if (lat_op == OP_PWORD) begin
                    pw_evt = 1'b1;
                    if (prog_ok) begin
                        mem_we    = 1'b1;
                        mem_wdata = mem_rdata | {new_chk, wlo};
                    end
                end else begin
                    other_evt = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_idx,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic              cpu_en, ecc_off, ecc_wr, go, cmd_done, ecc_err;
    logic [DATA_W-1:0] wlo, rd_lo;
    logic [CHK_W-1:0]  whi, rd_hi;
    logic [ADDR_W-1:0] row, mem_raddr, mem_waddr;
    logic [OP_W-1:0]   op;
    logic              init_done, prog_ok, done_set, rd_cap, rd_ecc;
    logic              pe_evt, pw_evt, other_evt, mem_we;
    logic [ROW_W-1:0]  mem_rdata, mem_wdata;

    otp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_en(cpu_en), .ecc_off(ecc_off), .ecc_wr(ecc_wr), .wlo(wlo),
        .whi(whi), .row(row), .go(go), .op(op), .cmd_done(cmd_done),
        .ecc_err(ecc_err), .init_done(init_done), .prog_ok(prog_ok),
        .done_set(done_set), .rd_cap(rd_cap), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_ecc(rd_ecc)
    );

    otp_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .cpu_en(cpu_en),
        .ecc_off(ecc_off), .ecc_wr(ecc_wr), .row(row), .wlo(wlo), .whi(whi),
        .prog_ok(prog_ok), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .init_done(init_done), .done_set(done_set), .rd_cap(rd_cap),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_ecc(rd_ecc), .pe_evt(pe_evt),
        .pw_evt(pw_evt), .other_evt(other_evt)
    );

    otp_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .pe_evt(pe_evt),
        .pw_evt(pw_evt), .other_evt(other_evt), .word(wlo), .prog_ok(prog_ok)
    );

    otp_fuse_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rd_addr(mem_raddr), .rd_data(mem_rdata), .wr_en(mem_we),
        .wr_addr(mem_waddr), .wr_data(mem_wdata)
    );
endmodule

// File: rtl/otp_cmd_ctrl_chk.sv
module otp_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [3:0]  bus_idx,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        init_done,
    input logic        done_set,
    input logic        cmd_done,
    input logic        mem_we,
    input logic        prog_ok,
    input logic        pe_evt,
    input logic        cpu_en,
    input logic        rd_cap,
    input logic        ecc_off,
    input logic        ecc_err
);
    // R1: no command can complete while the array is still being cleared
    assert_no_cmd_in_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !done_set);

    // R3: command-done is held unless a one is written to its bit
    assert_done_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !(bus_en && bus_we && bus_idx == 4'd6 && bus_wdata[1])) |=> cmd_done);

    // R4: upper read-data-high bits always read zero
    assert_rhi_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_idx == 4'd8) |-> (bus_rdata[31:9] == 23'd0));

    // R5: program-ok only rises right after a program-enable completion
    assert_unlock_by_pe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_ok) |-> $past(pe_evt));

    // R7: after the clearing phase the array is written only when unlocked
    assert_write_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && init_done) |-> prog_ok);

    // R8: withdrawing CPU access drops program-ok on the next cycle
    assert_ok_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en |=> !prog_ok);

    // R10: reads with checking disabled never raise ECC-detect
    assert_ecc_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && ecc_off) |=> !ecc_err);
endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .init_done(init_done), .done_set(done_set), .cmd_done(cmd_done),
    .mem_we(mem_we), .prog_ok(prog_ok), .pe_evt(pe_evt), .cpu_en(cpu_en),
    .rd_cap(rd_cap), .ecc_off(ecc_off), .ecc_err(ecc_err)
);

// File: tb/otp_cmd_ctrl_bench.sv
module otp_cmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [40:0] model [NROWS];

    otp_cmd_ctrl u_otp_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [8:0] chk9(input logic [31:0] d);
        logic [8:0] c = '0;
        for (int j = 0; j < 32; j++) c[j % 9] ^= d[j];
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_idx = idx;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic run_cmd(input logic [4:0] op, output logic seen);
        logic [31:0] s;
        seen = 1'b0;
        wr(4'd4, {26'd0, op, 1'b0});
        wr(4'd4, {26'd0, op, 1'b1});
        for (int k = 0; k < 30 && !seen; k++) begin
            rd(4'd6, s);
            seen = s[1];
        end
        wr(4'd4, {26'd0, op, 1'b0});
        wr(4'd6, 32'h2);
    endtask

    task automatic pe_word(input logic [31:0] w);
        logic seen;
        wr(4'd1, w);
        run_cmd(5'd2, seen);
    endtask

    task automatic unlock();
        pe_word(32'hF); pe_word(32'h4); pe_word(32'h8); pe_word(32'hD);
    endtask

    task automatic program_row(input int r, input logic [31:0] lo, input logic [8:0] hi,
                               input logic eccw, input logic do_unlock);
        logic seen;
        logic [8:0] c;
        wr(4'd0, 32'h8000 | (32'(eccw) << 8));
        wr(4'd3, 32'(r) << 6);
        if (do_unlock) unlock();
        wr(4'd1, lo);
        wr(4'd2, {23'd0, hi});
        run_cmd(5'd10, seen);
        c = eccw ? chk9(lo) : hi;
        if (do_unlock) model[r] = model[r] | {c, lo};
    endtask

    task automatic read_row(input int r, input logic eoff, output logic [31:0] lo,
                            output logic [31:0] hi, output logic err);
        logic seen;
        logic [31:0] s;
        wr(4'd0, 32'h8000 | (32'(eoff) << 9));
        wr(4'd3, 32'(r) << 6);
        run_cmd(5'd0, seen);
        rd(4'd7, lo);
        rd(4'd8, hi);
        rd(4'd6, s);
        err = s[17];
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] v, lo, hi;
        logic err, seen;
        int polls;
        for (int i = 0; i < NROWS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(4'd5, v); check("R1 status0 after reset", v, 32'h0);
        rd(4'd6, v); check("R1 status1 after reset", v, 32'h0);
        polls = 0;
        v = '0;
        while (!v[3] && polls < 1200) begin rd(4'd5, v); polls++; end
        check("R1 init done set", {31'd0, v[3]}, 32'd1);
        check("R1 fill length", {31'd0, polls >= 1000}, 32'd1);

        // R2: start without CPU access does nothing
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h1);
        repeat (10) @(negedge clk);
        rd(4'd6, v); check("R2 no run without cpu access", {31'd0, v[1]}, 32'd0);
        wr(4'd4, 32'h0);

        read_row(5, 1'b0, lo, hi, err);
        check("R1 cleared row data", lo, 32'h0);
        check("R4 cleared row check", hi, 32'h0);

        // R3: done held until a one is written
        wr(4'd0, 32'h8000);
        wr(4'd4, 32'h1);
        repeat (8) @(negedge clk);
        wr(4'd6, 32'h0);
        rd(4'd6, v); check("R3 done held", {31'd0, v[1]}, 32'd1);
        wr(4'd4, 32'h0);
        wr(4'd6, 32'h2);
        rd(4'd6, v); check("R3 done cleared", {31'd0, v[1]}, 32'd0);

        // R7: program without unlock leaves the row untouched
        program_row(7, 32'hDEAD_BEEF, 9'h1FF, 1'b0, 1'b0);
        rd(4'd6, v);
        read_row(7, 1'b1, lo, hi, err);
        check("R7 locked write ignored data", lo, 32'h0);
        check("R7 locked write ignored check", hi, 32'h0);

        // R6: wrong third word
        wr(4'd0, 32'h8000);
        pe_word(32'hF); pe_word(32'h4); pe_word(32'h9); pe_word(32'hD);
        rd(4'd5, v); check("R6 wrong word keeps locked", {31'd0, v[2]}, 32'd0);
        // R6: a read slipped in before the last word
        pe_word(32'hF); pe_word(32'h4); pe_word(32'h8);
        run_cmd(5'd0, seen);
        pe_word(32'hD);
        rd(4'd5, v); check("R6 interleaved read keeps locked", {31'd0, v[2]}, 32'd0);

        // R5 and R8
        unlock();
        rd(4'd5, v); check("R5 program ok after sequence", {31'd0, v[2]}, 32'd1);
        wr(4'd0, 32'h0);
        rd(4'd5, v); check("R8 cpu access drop clears ok", {31'd0, v[2]}, 32'd0);

        // R7 accumulation and R8 clear after write
        program_row(9, 32'h0000_00F0, 9'h000, 1'b0, 1'b1);
        rd(4'd5, v); check("R8 ok clears after program", {31'd0, v[2]}, 32'd0);
        program_row(9, 32'h0F00_0000, 9'h000, 1'b0, 1'b1);
        // R4: junk above bit 15 of the row select is ignored
        wr(4'd0, 32'h8200);
        wr(4'd3, 32'hFFFF_0000 | (32'd9 << 6));
        run_cmd(5'd0, seen);
        rd(4'd7, lo);
        check("R7 bits accumulate", lo, 32'h0F00_00F0);
        check("R4 upper row select ignored", lo, model[9][31:0]);

        // R9: generated check field
        program_row(20, 32'h1234_5678, 9'h0AA, 1'b1, 1'b1);
        read_row(20, 1'b0, lo, hi, err);
        check("R9 generated check field", hi, {23'd0, chk9(32'h1234_5678)});
        check("R10 consistent row no detect", {31'd0, err}, 32'd0);

        // R10: inconsistent check field
        program_row(21, 32'h0000_0001, 9'h000, 1'b0, 1'b1);
        read_row(21, 1'b0, lo, hi, err);
        check("R10 mismatch detected", {31'd0, err}, 32'd1);
        read_row(21, 1'b1, lo, hi, err);
        check("R10 detect disabled", {31'd0, err}, 32'd0);
        check("R4 data with detect disabled", lo, 32'h1);

        // Random programs and reads against the model
        void'($urandom(32'd1357));
        for (int it = 0; it < 30; it++) begin
            int r;
            logic [31:0] rl;
            logic [8:0] rh;
            logic eccw, eoff;
            logic [8:0] eh;
            r = 32 + int'($urandom_range(0, 15));
            rl = $urandom & $urandom;
            rh = 9'($urandom);
            eccw = 1'($urandom);
            eoff = 1'($urandom);
            program_row(r, rl, rh, eccw, 1'b1);
            read_row(r, eoff, lo, hi, err);
            eh = model[r][40:32];
            check("R7 random data", lo, model[r][31:0]);
            check("R9 random check", hi, {23'd0, eh});
            check("R10 random detect", {31'd0, err},
                  {31'd0, !eoff && (eh != chk9(model[r][31:0]))});
        end

        summary();
    end
endmodule